// File: doc/BRIEF.md
# Configurable Receive Word Aligner

This block sits directly behind a receive deserializer. Each clock it takes one 10-bit parallel word from the line and recovers the symbol boundary. It keeps a short history of received words and looks for a configurable alignment pattern at every one of the ten possible bit offsets at once. Once it has settled on an offset, it emits each word realigned to that offset.

Three policies control how the boundary moves. In manual mode the boundary snaps to a pattern while an enable is held. In slip mode an external controller steps it one bit at a time. In automatic mode a synchronization state machine acquires the boundary and monitors it, dropping lock when a downstream decoder reports too many invalid code groups. Three optional stages sit in the path: input polarity inversion, output bit-order reversal and a run-length monitor. Every selector and the pattern are static configuration.

Top module: `rx_word_aligner`

## Requirements
- R1: While `rst_n` is low, `rx_aligned`, `aligned_valid`, `pat_det`, `sync_ok` and `rl_viol` are all 0, the boundary is offset 0 and the word history is cleared to zeros.
- R2: Bit 0 of `rx_data` is the earliest bit on the line. Stream bits are numbered from bit 0 of the word sampled four edges earlier. The word registered on `rx_aligned` at an edge is stream bits offset..offset+9, taken with the offset held before that edge.
- R3: `pat_len_sel` picks the pattern length: 0=7, 1=8, 2=10, 3=16, 4=20, 5=32 bits, and 6 or 7 mean 10. Only `pattern[L-1:0]` is compared, with `pattern[0]` against the first stream bit, so patterns of 16 or more bits span several received words.
- R4: A pattern matches at offset k when stream bits k..k+L-1 equal the pattern. When several offsets match in the same cycle, the lowest offset is selected.
- R5: Mode 0 (manual): while `align_en` is 1 and any offset matches, the boundary moves to the selected offset. While `align_en` is 0 the boundary does not change. Mode 3 holds the boundary.
- R6: Mode 1 (slip): each 0-to-1 transition of `slip_req` adds one to the boundary, and 9 wraps to 0. Holding `slip_req` high causes no further steps.
- R7: Mode 2 (automatic): a cycle whose window matches at the current boundary counts as a comma. Three such cycles in a row raise `sync_ok`. A match only at another offset moves the boundary there and restarts the count at 1. A cycle with no match clears the count.
- R8: While synchronized, each cycle with `cg_bad`=1 adds one error. The fourth outstanding error drops `sync_ok`. While errors are outstanding, every run of four consecutive cycles with `cg_bad`=0 removes one error. `cg_bad` is ignored while unsynchronized.
- R9: After losing sync, the automatic mode reacquires lock, at a new offset if needed, under the rules of R7.
- R10: With `inv_en`=1, every received bit is complemented before storage, the pattern search and the run-length monitor.
- R11: With `rev_en`=1, output bit j equals aligned bit 9-j.
- R12: The run-length monitor counts consecutive identical bits across word boundaries. The count saturates at 63 and restarts at 1 on a change. `rl_viol` is registered high for a word if the count exceeds `rl_max` at any bit of that word.
- R13: `aligned_valid` is registered low on the edge where the boundary changes and high otherwise. `pat_det` is registered high when the window matches at the boundary in force before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Boundary policy: 0 manual, 1 slip, 2 automatic, 3 hold |
| pat_len_sel | input | 3 | Pattern length code |
| pattern | input | 32 | Alignment pattern, bit 0 first on the line |
| align_en | input | 1 | Manual-mode lock enable |
| slip_req | input | 1 | Slip request, acts on rising edges |
| cg_bad | input | 1 | Invalid code group flag for the current output word |
| inv_en | input | 1 | Complement incoming bits |
| rev_en | input | 1 | Reverse bit order of output word |
| rl_max | input | 6 | Largest allowed run of identical bits |
| rx_data | input | 10 | Deserialized input word |
| rx_aligned | output | 10 | Realigned output word |
| aligned_valid | output | 1 | Output word not affected by a boundary change |
| pat_det | output | 1 | Pattern found at the current boundary |
| sync_ok | output | 1 | Automatic-mode lock status |
| rl_viol | output | 1 | Run-length violation in this word |

## Verification
Random streams with the boundary fixed at zero check the data path and bit numbering. Patterns placed at chosen bit offsets, for every length code, show whether a match is found at the right offset, including multi-word patterns. A long zero run against an all-zero 7-bit pattern produces several matches in one window and separates lowest-offset priority from any other choice. Error bursts interleaved with good runs show whether the recovery window is honoured: two bad, four good and then three more bad must keep lock until the last bad word, which a counter without recovery would not. Slip pulses beyond ten and held slip levels expose wrap and edge-detection faults.

// File: rtl/wa_pkg.sv
package wa_pkg;
  typedef enum logic [1:0] {
    AL_MANUAL = 2'd0,
    AL_SLIP   = 2'd1,
    AL_AUTO   = 2'd2,
    AL_HOLD   = 2'd3
  } al_mode_e;

  // pattern length in bits for a length code
  function automatic int pat_len(input logic [2:0] sel);
    case (sel)
      3'd0: return 7;
      3'd1: return 8;
      3'd3: return 16;
      3'd4: return 20;
      3'd5: return 32;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/wa_match.sv
module wa_match #(
  parameter int W  = 10,
  parameter int PW = 32,
  parameter int NB = 50,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] win,
  input  logic [PW-1:0] pat,
  input  logic [PW-1:0] mask,
  output logic [W-1:0]  hit,
  output logic          any_hit,
  output logic [IW-1:0] first
);
  for (genvar k = 0; k < W; k++) begin : g_off
    assign hit[k] = (((win[k +: PW]) ^ pat) & mask) == '0;
  end

  assign any_hit = |hit;

  always_comb begin
    first = '0;
    for (int k = W - 1; k >= 0; k--)
      if (hit[k]) first = IW'(k);
  end

  // R4: the chosen offset matches and no lower offset does
  a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (hit[first] && ((hit & ((W'(1) << first) - W'(1))) == '0)));
endmodule

// File: rtl/wa_runlen.sv
module wa_runlen #(
  parameter int W   = 10,
  parameter int RLW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   din,
  input  logic [RLW-1:0] rl_max,
  output logic           viol
);
  logic           last_q, last_d;
  logic [RLW-1:0] run_q, run_d;
  logic           viol_d;

  always_comb begin
    last_d = last_q;
    run_d  = run_q;
    viol_d = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (din[i] == last_d) begin
        if (run_d != '1) run_d = run_d + 1'b1;
      end else begin
        run_d = RLW'(1);
      end
      last_d = din[i];
      if (run_d > rl_max) viol_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      run_q  <= '0;
      viol   <= 1'b0;
    end else begin
      last_q <= last_d;
      run_q  <= run_d;
      viol   <= viol_d;
    end
  end

  // R12: a saturating count can never exceed the largest limit
  a_r12_sat_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (rl_max == '1) |=> !viol);
endmodule

// File: rtl/wa_bctl.sv
module wa_bctl import wa_pkg::*; #(
  parameter int W      = 10,
  parameter int SYNC_N = 3,
  parameter int LOSS_N = 4,
  parameter int GOOD_N = 4,
  localparam int IW = $clog2(W),
  localparam int CW = $clog2(SYNC_N + 1),
  localparam int EW = $clog2(LOSS_N + 1),
  localparam int GW = $clog2(GOOD_N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          align_en,
  input  logic          slip_req,
  input  logic          cg_bad,
  input  logic [W-1:0]  hit,
  input  logic          any_hit,
  input  logic [IW-1:0] first,
  output logic [IW-1:0] bnd,
  output logic          bnd_chg,
  output logic          synced
);
  al_mode_e      md;
  logic [IW-1:0] bnd_d;
  logic          sync_d, slip_q, slip_rise, hit_cur;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [EW-1:0] err_q, err_d;
  logic [GW-1:0] good_q, good_d;

  assign md        = al_mode_e'(mode);
  assign slip_rise = slip_req & ~slip_q;
  assign hit_cur   = hit[bnd];
  assign bnd_chg   = bnd_d != bnd;

  always_comb begin
    bnd_d  = bnd;
    sync_d = synced;
    cnt_d  = cnt_q;
    err_d  = err_q;
    good_d = good_q;
    case (md)
      AL_MANUAL: if (align_en && any_hit) bnd_d = first;
      AL_SLIP:   if (slip_rise) bnd_d = (bnd == IW'(W - 1)) ? '0 : bnd + 1'b1;
      AL_AUTO: begin
        if (!synced) begin
          if (hit_cur) begin
            if (cnt_q == CW'(SYNC_N - 1)) begin
              sync_d = 1'b1;
              cnt_d  = '0;
              err_d  = '0;
              good_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else if (any_hit) begin
            bnd_d = first;
            cnt_d = CW'(1);
          end else begin
            cnt_d = '0;
          end
        end else if (cg_bad) begin
          good_d = '0;
          if (err_q == EW'(LOSS_N - 1)) begin
            sync_d = 1'b0;
            err_d  = '0;
            cnt_d  = '0;
          end else begin
            err_d = err_q + 1'b1;
          end
        end else if (err_q != '0) begin
          if (good_q == GW'(GOOD_N - 1)) begin
            good_d = '0;
            err_d  = err_q - 1'b1;
          end else begin
            good_d = good_q + 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnd    <= '0;
      synced <= 1'b0;
      cnt_q  <= '0;
      err_q  <= '0;
      good_q <= '0;
      slip_q <= 1'b0;
    end else begin
      bnd    <= bnd_d;
      synced <= sync_d;
      cnt_q  <= cnt_d;
      err_q  <= err_d;
      good_q <= good_d;
      slip_q <= slip_req;
    end
  end

  // R2: boundary stays inside the word
  a_r2_bnd_range: assert property (@(posedge clk) disable iff (!rst_n)
    bnd < IW'(W));
  // R5: manual boundary frozen without enable
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (md == AL_MANUAL && !align_en) |=> $stable(bnd));
  // R6: one step per slip edge, wrapping
  a_r6_slip_step: assert property (@(posedge clk) disable iff (!rst_n)
    (md == AL_SLIP && slip_req && !slip_q) |=>
      bnd == (($past(bnd) == IW'(W - 1)) ? '0 : $past(bnd) + 1'b1));
  // R7: lock only follows a comma at the boundary
  a_r7_gain: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synced) |-> $past(md == AL_AUTO && hit_cur));
  // R8: lock only lost on a bad code group
  a_r8_lose: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(synced) |-> $past(cg_bad));
endmodule

// File: rtl/rx_word_aligner.sv
module rx_word_aligner import wa_pkg::*; #(
  parameter int W      = 10,
  parameter int PW     = 32,
  parameter int RLW    = 6,
  parameter int SYNC_N = 3,
  parameter int LOSS_N = 4,
  parameter int GOOD_N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     mode,
  input  logic [2:0]     pat_len_sel,
  input  logic [PW-1:0]  pattern,
  input  logic           align_en,
  input  logic           slip_req,
  input  logic           cg_bad,
  input  logic           inv_en,
  input  logic           rev_en,
  input  logic [RLW-1:0] rl_max,
  input  logic [W-1:0]   rx_data,
  output logic [W-1:0]   rx_aligned,
  output logic           aligned_valid,
  output logic           pat_det,
  output logic           sync_ok,
  output logic           rl_viol
);
  localparam int IW = $clog2(W);
  localparam int HW = (PW + 2 * (W - 1)) / W;   // words spanned by any match
  localparam int NB = HW * W;

  logic [W-1:0]  din;
  logic [W-1:0]  hist [HW-1];
  logic [NB-1:0] win;
  logic [PW-1:0] mask;
  logic [W-1:0]  hit, aligned, shaped;
  logic          any_hit, bnd_chg;
  logic [IW-1:0] first, bnd;

  assign din = rx_data ^ {W{inv_en}};

  // newest word on top, oldest word at bit 0
  assign win[NB-1 -: W] = din;
  for (genvar i = 0; i < HW - 1; i++) begin : g_win
    assign win[W*(HW-2-i) +: W] = hist[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HW - 1; i++) hist[i] <= '0;
    end else begin
      hist[0] <= din;
      for (int i = 1; i < HW - 1; i++) hist[i] <= hist[i-1];
    end
  end

  always_comb begin
    mask = '0;
    for (int i = 0; i < PW; i++)
      if (i < pat_len(pat_len_sel)) mask[i] = 1'b1;
  end

  wa_match #(.W(W), .PW(PW), .NB(NB)) u_match (
    .clk(clk), .rst_n(rst_n), .win(win), .pat(pattern), .mask(mask),
    .hit(hit), .any_hit(any_hit), .first(first)
  );

  wa_bctl #(.W(W), .SYNC_N(SYNC_N), .LOSS_N(LOSS_N), .GOOD_N(GOOD_N)) u_bctl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .align_en(align_en),
    .slip_req(slip_req), .cg_bad(cg_bad), .hit(hit), .any_hit(any_hit),
    .first(first), .bnd(bnd), .bnd_chg(bnd_chg), .synced(sync_ok)
  );

  wa_runlen #(.W(W), .RLW(RLW)) u_rl (
    .clk(clk), .rst_n(rst_n), .din(din), .rl_max(rl_max), .viol(rl_viol)
  );

  assign aligned = win[bnd +: W];
  for (genvar j = 0; j < W; j++) begin : g_rev
    assign shaped[j] = rev_en ? aligned[W-1-j] : aligned[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_aligned    <= '0;
      aligned_valid <= 1'b0;
      pat_det       <= 1'b0;
    end else begin
      rx_aligned    <= shaped;
      aligned_valid <= !bnd_chg;
      pat_det       <= hit[bnd];
    end
  end

  // R13: a boundary move marks the next output invalid
  a_r13_move_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_chg |=> !aligned_valid);
  // R13: a steady boundary keeps the output valid
  a_r13_steady_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd_chg |=> aligned_valid);
endmodule

// File: tb/sim_rx_word_aligner.sv
module sim_rx_word_aligner;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [1:0]  mode;
  logic [2:0]  lsel;
  logic [31:0] pattern;
  logic        align_en, slip_req, cg_bad, inv_en, rev_en;
  logic [5:0]  rl_max;
  logic [9:0]  rx_data;
  logic [9:0]  rx_aligned;
  logic        aligned_valid, pat_det, sync_ok, rl_viol;

  rx_word_aligner u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pat_len_sel(lsel),
    .pattern(pattern), .align_en(align_en), .slip_req(slip_req),
    .cg_bad(cg_bad), .inv_en(inv_en), .rev_en(rev_en), .rl_max(rl_max),
    .rx_data(rx_data), .rx_aligned(rx_aligned),
    .aligned_valid(aligned_valid), .pat_det(pat_det), .sync_ok(sync_ok),
    .rl_viol(rl_viol)
  );

  int    checks = 0, fails = 0;
  string tag = "R1";
  bit    sq[$];
  bit    txq[$];
  int    m_bnd, m_cnt, m_err, m_good, m_run;
  bit    m_sync, m_slip, m_last;
  logic [9:0] e_dout;
  bit    e_valid, e_det, e_rl;

  function automatic int plen(input logic [2:0] s);
    case (s)
      3'd0: return 7;   3'd1: return 8;  3'd3: return 16;
      3'd4: return 20;  3'd5: return 32; default: return 10;
    endcase
  endfunction

  task automatic check(input string req, input string sig, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, sig, act, exp);
    end
  endtask

  task automatic put_bits(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) txq.push_back(v[i]);
  endtask

  task automatic put_rand(input int n);
    for (int i = 0; i < n; i++) txq.push_back(1'($urandom % 2));
  endtask

  task automatic put_run(input bit b, input int n);
    for (int i = 0; i < n; i++) txq.push_back(b);
  endtask

  task automatic model_clear();
    sq.delete();
    txq.delete();
    for (int i = 0; i < 50; i++) sq.push_back(1'b0);
    m_bnd = 0; m_cnt = 0; m_err = 0; m_good = 0; m_run = 0;
    m_sync = 0; m_slip = 0; m_last = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "rx_aligned", rx_aligned, 0);
    check("R1", "flags", {aligned_valid, pat_det, sync_ok, rl_viol}, 0);
    rst_n = 1'b1;
  endtask

  task automatic step();
    logic [9:0] w;
    bit hits[10];
    int first, L, old;
    bit rise;
    for (int i = 0; i < 10; i++) w[i] = (txq.size() > 0) ? txq.pop_front() : 1'($urandom % 2);
    rx_data = w;
    for (int i = 0; i < 10; i++) sq.push_back(w[i] ^ inv_en);
    while (sq.size() > 50) void'(sq.pop_front());
    L = plen(lsel);
    first = -1;
    for (int k = 0; k < 10; k++) begin
      hits[k] = 1'b1;
      for (int i = 0; i < L; i++) if (sq[k+i] != pattern[i]) hits[k] = 1'b0;
      if (hits[k] && first < 0) first = k;
    end
    for (int j = 0; j < 10; j++) e_dout[j] = rev_en ? sq[m_bnd+9-j] : sq[m_bnd+j];
    e_det = hits[m_bnd];
    old = m_bnd;
    rise = slip_req && !m_slip;
    m_slip = slip_req;
    case (mode)
      2'd0: if (align_en && first >= 0) m_bnd = first;
      2'd1: if (rise) m_bnd = (m_bnd + 1) % 10;
      2'd2: begin
        if (!m_sync) begin
          if (hits[m_bnd]) begin
            m_cnt++;
            if (m_cnt == 3) begin m_sync = 1; m_cnt = 0; m_err = 0; m_good = 0; end
          end else if (first >= 0) begin m_bnd = first; m_cnt = 1; end
          else m_cnt = 0;
        end else if (cg_bad) begin
          m_good = 0; m_err++;
          if (m_err == 4) begin m_sync = 0; m_err = 0; m_cnt = 0; end
        end else if (m_err > 0) begin
          m_good++;
          if (m_good == 4) begin m_good = 0; m_err--; end
        end
      end
      default: ;
    endcase
    e_valid = (m_bnd == old);
    e_rl = 1'b0;
    for (int i = 0; i < 10; i++) begin
      bit b = sq[40+i];
      if (b == m_last) begin if (m_run < 63) m_run++; end else m_run = 1;
      m_last = b;
      if (m_run > int'(rl_max)) e_rl = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "rx_aligned", rx_aligned, e_dout);
    check("R13", "aligned_valid", aligned_valid, e_valid);
    check("R13", "pat_det", pat_det, e_det);
    check(tag, "sync_ok", sync_ok, m_sync);
    check("R12", "rl_viol", rl_viol, e_rl);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic config_default();
    mode = 2'd0; lsel = 3'd2; pattern = 32'h0000_00FA;
    align_en = 0; slip_req = 0; cg_bad = 0; inv_en = 0; rev_en = 0;
    rl_max = 6'd63; rx_data = '0;
  endtask

  localparam logic [9:0] COMMA = 10'b0011111010;

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired before the end of the run");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    config_default();
    pattern = {22'd0, COMMA};
    tag = "R1";
    do_reset();

    // R2: plain data path at boundary zero
    tag = "R2";
    put_rand(200);
    steps(20);

    // R5: manual lock, then hold without enable
    tag = "R5";
    do_reset();
    align_en = 1;
    put_rand(23); put_bits({22'd0, COMMA}, 10); put_rand(60);
    steps(10);
    align_en = 0;
    put_rand(6); put_bits({22'd0, COMMA}, 10); put_rand(60);
    steps(10);
    mode = 2'd3; align_en = 1;
    put_rand(2); put_bits({22'd0, COMMA}, 10); put_rand(40);
    steps(8);

    // R3: every length code, patterns spanning several words
    for (int s = 0; s < 6; s++) begin
      tag = "R3";
      config_default();
      do_reset();
      lsel = 3'(s); pattern = 32'hA5C3_3C5A; align_en = 1;
      put_rand(50); put_rand(7 + s); put_bits(pattern, plen(lsel)); put_rand(60);
      steps(14);
    end

    // R4: zero run gives several matches in one window
    tag = "R4";
    config_default();
    do_reset();
    lsel = 3'd0; pattern = 32'h0; align_en = 1;
    put_run(1, 63); put_run(0, 25); put_run(1, 40);
    steps(14);

    // R6: slip edges with wrap and held level
    tag = "R6";
    config_default();
    do_reset();
    mode = 2'd1;
    for (int p = 0; p < 12; p++) begin
      slip_req = 1; step();
      slip_req = 0; step();
    end
    slip_req = 1; steps(4);
    slip_req = 0; step();

    // R7: automatic acquisition
    tag = "R7";
    config_default();
    do_reset();
    mode = 2'd2; pattern = {22'd0, COMMA};
    put_run(0, 4);
    for (int c = 0; c < 6; c++) put_bits({22'd0, COMMA}, 10);
    for (int c = 0; c < 20; c++) put_bits(32'h155, 10);
    steps(14);
    check("R7", "sync_ok after commas", sync_ok, 1);

    // R8: error accounting with recovery window
    tag = "R8";
    for (int c = 0; c < 30; c++) put_bits(32'h155, 10);
    cg_bad = 1; steps(2);
    cg_bad = 0; steps(4);
    cg_bad = 1; steps(2);
    check("R8", "sync_ok with three errors", sync_ok, 1);
    step();
    check("R8", "sync_ok after fourth error", sync_ok, 0);
    cg_bad = 0;

    // R9: reacquire at a different offset
    tag = "R9";
    txq.delete();
    put_run(0, 7);
    for (int c = 0; c < 8; c++) put_bits({22'd0, COMMA}, 10);
    for (int c = 0; c < 10; c++) put_bits(32'h155, 10);
    steps(16);
    check("R9", "sync_ok reacquired", sync_ok, 1);

    // R10: polarity inversion before the search
    tag = "R10";
    config_default();
    do_reset();
    inv_en = 1; align_en = 1; pattern = {22'd0, COMMA};
    put_rand(35); put_bits(~{22'd0, COMMA}, 10); put_rand(60);
    steps(12);

    // R11: reversed output at a nonzero offset
    tag = "R11";
    config_default();
    do_reset();
    mode = 2'd1; rev_en = 1;
    put_rand(300);
    for (int p = 0; p < 3; p++) begin slip_req = 1; step(); slip_req = 0; step(); end
    steps(10);

    // R12: runs around the limit, then saturation
    tag = "R12";
    config_default();
    do_reset();
    rl_max = 6'd4;
    put_run(1, 3); put_run(0, 4); put_run(1, 5); put_run(0, 6); put_run(1, 2);
    put_rand(40);
    steps(8);
    rl_max = 6'd63;
    put_run(1, 120);
    steps(12);
    check("R12", "rl_viol saturated run", rl_viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule